// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Controller

This block sits between the frequency dividers of a clock generator and its output pads. It takes a set of raw divided clocks and passes each one to a pad only while that output is enabled and the chip is not powered down. The gating is glitch-free: an output only ever stops after a falling edge of its own source, and it only ever restarts on a rising edge. Every pulse that reaches a pad therefore has the full width of its source's high phase.

Power-down comes from an asynchronous active-low pin. The pin is brought into the CPU reference clock domain and must read low on two consecutive rising edges before it is accepted. The accepted request drops an enable that stops the crystal oscillator and the VCOs. It also removes the permission of every gated output, and each output then parks low at a falling edge of its own clock. On release, the oscillator enable returns first, and the outputs follow on later rising edges.

The block also forms the 4-bit frequency-select code. It captures four strap pins once after reset, and a select bit can replace that code with a register value. A single control bit turns off the output drivers through an output-enable line for the pads.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: After `pd_ni` falls and stays low, `core_run_o` goes low at the 4th rising edge of `clk_cpu_i` that follows. This covers two synchronizer flops plus the qualification on two consecutive synchronized samples. It stays high through the 3rd such edge.
- R2: A low pulse on `pd_ni` that covers only one rising edge of `clk_cpu_i` never lowers `core_run_o`. A low pulse that covers exactly two rising edges lowers it at the 4th edge, and it returns high at the 5th.
- R3: After `pd_ni` rises, `core_run_o` returns high at the 3rd rising edge of `clk_cpu_i`, and it is still low after the 2nd. Every output that is enabled then toggles again.
- R4: While power-down is accepted, every gated output and the free-running output stay low.
- R5: An output pulse never starts or ends in the middle of its source's high phase. Every high pulse on an output lasts exactly one high phase of its source clock.
- R6: An output whose bit in `en_i` is 0 stays low and does not toggle. Outputs whose bit is 1 keep toggling.
- R7: The free-running output ignores `en_i` and keeps toggling even when `en_i` is all zeros. Only power-down stops it.
- R8: `fs_pin_i` is captured at the first rising edge of `clk_cpu_i` after reset is released. Later changes on the pins do not alter `fs_eff_o` while `fs_sel_i` is 0.
- R9: While `fs_sel_i` is 1, `fs_eff_o` equals `fs_reg_i`. While it is 0, `fs_eff_o` equals the captured pin code.
- R10: `clk_oe_o` is 0 while `hiz_i` is 1 (all pads in high impedance) and 1 while `hiz_i` is 0.
- R11: During reset, all outputs are low, `core_run_o` is 1, and `fs_eff_o` is 0000 when `fs_sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU reference clock; domain of qualification and control |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to `clk_cpu_i` |
| pd_ni | input | 1 | Asynchronous active-low power-down pin |
| src_clk_i | input | N_OUT | Raw divided clocks, one per gated output |
| free_src_i | input | 1 | Raw clock of the free-running memory output |
| en_i | input | N_OUT | Per-output enable, 1 lets the output run |
| hiz_i | input | 1 | 1 puts all output pads in high impedance |
| fs_pin_i | input | 4 | Frequency-select strap pins |
| fs_sel_i | input | 1 | 0 selects captured pins, 1 selects `fs_reg_i` |
| fs_reg_i | input | 4 | Register override frequency code |
| clk_o | output | N_OUT | Gated clocks, low when disabled or powered down |
| free_clk_o | output | 1 | Free-running memory clock, gated only by power-down |
| clk_oe_o | output | 1 | Pad output enable, 0 means high impedance |
| core_run_o | output | 1 | Oscillator and VCO enable, 0 in power-down |
| fs_eff_o | output | 4 | Effective frequency-select code |

## Verification
`core_run_o` is due at a fixed count of CPU rising edges after a pin change: the 4th edge for entry into power-down, the 3rd for release, and the 5th for release after a two-edge pulse. `fs_eff_o` and `clk_oe_o` follow their controls within one cycle. The driver stamps every expected item with the CPU cycle at which it falls due. The monitor compares each item at the falling edge of that cycle, away from any register update. Gated outputs settle only after their own source clock's synchronizer, so their activity is judged over windows that open well after that settling time. Pulse widths are measured on every output edge against the source half-period.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;
  localparam int FS_W        = 4;
  localparam int DEF_SYNC    = 2;
  localparam int DEF_OUTPUTS = 4;
  typedef logic [FS_W-1:0] fs_code_t;
endpackage

// File: rtl/ckg_pd_qual.sv
`timescale 1ns/1ps
module ckg_pd_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic pd_req_o
);
  // two-flop synchronizer, then history flop for two-sample qualification
  logic meta_q, sync_q, hist_q, req_q;
  logic meta_nxt, sync_nxt, hist_nxt, req_nxt;

  always_comb begin
    meta_nxt = pd_ni;
    sync_nxt = meta_q;
    hist_nxt = sync_q;
    req_nxt  = ~sync_q & ~hist_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      meta_q <= meta_nxt;
      sync_q <= sync_nxt;
      hist_q <= hist_nxt;
      req_q  <= req_nxt;
    end
  end

  assign pd_req_o = req_q;

  // R1: request only rises after two consecutive low synchronized samples
  assert_pd_two_samples_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> (!$past(sync_q) && !$past(hist_q)));

  // R3: request only falls when the synchronized pin read high
  assert_pd_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(sync_q));
endmodule

// File: rtl/ckg_fs_sel.sv
`timescale 1ns/1ps
module ckg_fs_sel
  import ckg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fs_code_t fs_pin_i,
  input  logic     fs_sel_i,
  input  fs_code_t fs_reg_i,
  output fs_code_t fs_eff_o
);
  fs_code_t lat_q, lat_nxt;
  logic     cap_q, cap_nxt;
  logic     lat_en;

  always_comb begin
    lat_en  = ~cap_q;
    lat_nxt = lat_en ? fs_pin_i : lat_q;
    cap_nxt = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cap_q <= 1'b0;
    end else begin
      lat_q <= lat_nxt;
      cap_q <= cap_nxt;
    end
  end

  assign fs_eff_o = fs_sel_i ? fs_reg_i : lat_q;

  // R8: once captured, the strap code never changes
  assert_fs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> $stable(lat_q));

  // R9: with pins selected and capture done, the effective code is steady
  assert_fs_pinsrc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_sel_i && !$past(fs_sel_i) && cap_q && $past(cap_q)) |-> $stable(fs_eff_o));
endmodule

// File: rtl/ckg_gate_cell.sv
`timescale 1ns/1ps
module ckg_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic allow_i,
  output logic clk_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sh_q, sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[LAST-1:0], allow_i};
  end

  // gate updates only while the source is low, so edges are never cut
  always_ff @(negedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign clk_o = clk_src_i & sh_q[LAST];

  // R5: gate opens only after the permission crossed every stage
  assert_gate_open_path_R5: assert property (@(negedge clk_src_i) disable iff (!rst_ni)
    $rose(sh_q[LAST]) |-> $past(sh_q[LAST-1]));
endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
  import ckg_pkg::*;
#(
  parameter int N_OUT       = DEF_OUTPUTS,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk_cpu_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic [N_OUT-1:0] src_clk_i,
  input  logic             free_src_i,
  input  logic [N_OUT-1:0] en_i,
  input  logic             hiz_i,
  input  logic [FS_W-1:0]  fs_pin_i,
  input  logic             fs_sel_i,
  input  logic [FS_W-1:0]  fs_reg_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             free_clk_o,
  output logic             clk_oe_o,
  output logic             core_run_o,
  output logic [FS_W-1:0]  fs_eff_o
);
  logic             pd_req;
  logic [N_OUT-1:0] allow_q, allow_nxt;
  logic             free_allow_q, free_allow_nxt;

  ckg_pd_qual u_pd_qual (
    .clk_i    (clk_cpu_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .pd_req_o (pd_req)
  );

  ckg_fs_sel u_fs_sel (
    .clk_i    (clk_cpu_i),
    .rst_ni   (rst_ni),
    .fs_pin_i (fs_pin_i),
    .fs_sel_i (fs_sel_i),
    .fs_reg_i (fs_reg_i),
    .fs_eff_o (fs_eff_o)
  );

  always_comb begin
    allow_nxt      = en_i & {N_OUT{~pd_req}};
    free_allow_nxt = ~pd_req;
  end

  // permissions registered one cycle after the core enable changes
  always_ff @(posedge clk_cpu_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_q      <= '0;
      free_allow_q <= 1'b0;
    end else begin
      allow_q      <= allow_nxt;
      free_allow_q <= free_allow_nxt;
    end
  end

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_cell
    ckg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_src_i (src_clk_i[gi]),
      .rst_ni    (rst_ni),
      .allow_i   (allow_q[gi]),
      .clk_o     (clk_o[gi])
    );
  end

  ckg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_free_cell (
    .clk_src_i (free_src_i),
    .rst_ni    (rst_ni),
    .allow_i   (free_allow_q),
    .clk_o     (free_clk_o)
  );

  assign core_run_o = ~pd_req;
  assign clk_oe_o   = ~hiz_i;

  // R4: an accepted power-down withdraws every permission on the next edge
  assert_pd_stops_all_R4: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    pd_req |=> (allow_q == '0 && !free_allow_q));

  // R6: a cleared enable withdraws that output's permission
  assert_en_blocks_R6: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    (en_i == '0) |=> (allow_q == '0));

  // R7: the free output's permission tracks only power-down
  assert_free_ignores_en_R7: assert property (@(posedge clk_cpu_i) disable iff (!rst_ni)
    (!pd_req && (en_i == '0)) |=> free_allow_q);
endmodule

// File: tb/clkout_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int HALF [N+1] = '{CLK_PERIOD/2, 15, 10, 7, 6};

  typedef struct {
    int         due;
    int         kind;
    int         idx;
    logic [3:0] exp;
    string      req;
  } item_t;

  logic clk = 0, src1 = 0, src2 = 0, src3 = 0, srcf = 0;
  logic rst_n = 0, pd_n = 1, hiz = 0, fs_sel = 0;
  logic [N-1:0] en = '1;
  logic [3:0] fs_pin = 4'b1010, fs_reg = 4'b0000;
  logic [N-1:0] clk_out;
  logic free_out, oe, core_run;
  logic [3:0] fs_eff;
  wire  [N-1:0] srcs = {src3, src2, src1, clk};
  wire  [N:0]   outs = {free_out, clk_out};

  int cyc = 0, n_chk = 0, n_pass = 0;
  time win_t = 0;
  time lr_arr [N+1];
  int  bad_arr [N+1];
  item_t sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(HALF[1]) src1 = ~src1;
  always #(HALF[2]) src2 = ~src2;
  always #(HALF[3]) src3 = ~src3;
  always #(HALF[4]) srcf = ~srcf;
  always @(posedge clk) cyc <= cyc + 1;

  clkout_gate_ctrl #(.N_OUT(N)) u_clkout_gate_ctrl (
    .clk_cpu_i (clk), .rst_ni (rst_n), .pd_ni (pd_n),
    .src_clk_i (srcs), .free_src_i (srcf), .en_i (en), .hiz_i (hiz),
    .fs_pin_i (fs_pin), .fs_sel_i (fs_sel), .fs_reg_i (fs_reg),
    .clk_o (clk_out), .free_clk_o (free_out), .clk_oe_o (oe),
    .core_run_o (core_run), .fs_eff_o (fs_eff)
  );

  // R5 pulse-width monitors, one per output
  for (genvar g = 0; g <= N; g++) begin : g_mon
    time lr = 0;
    int  bad = 0;
    always @(posedge outs[g]) lr = $time;
    always @(negedge outs[g]) if ($time - lr != HALF[g]) bad++;
    assign lr_arr[g]  = lr;
    assign bad_arr[g] = bad;
  end

  function automatic logic [3:0] probe(int kind, int idx);
    int tot;
    case (kind)
      0: return {3'b0, core_run};
      1: return fs_eff;
      2: return {3'b0, oe};
      3: return {3'b0, lr_arr[idx] > win_t};
      4: return {3'b0, |outs};
      default: begin
        tot = 0;
        for (int i = 0; i <= N; i++) tot += bad_arr[i];
        return (tot > 15) ? 4'hF : 4'(tot);
      end
    endcase
  endfunction

  task automatic push(int dly, int kind, int idx, logic [3:0] exp, string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic open_window();
    win_t = $time;
  endtask

  // monitor: compares due items at the falling edge of their cycle
  initial forever begin
    @(negedge clk);
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        logic [3:0] act;
        act = probe(sb_q[i].kind, sb_q[i].idx);
        n_chk++;
        if (act === sb_q[i].exp) n_pass++;
        else $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                      sb_q[i].req, sb_q[i].kind, sb_q[i].idx, act, sb_q[i].exp);
        sb_q.delete(i);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  initial begin
    // R11: reset state
    wait_cyc(3);
    push(1, 4, 0, 4'h0, "R11 outputs low in reset");
    push(1, 0, 0, 4'h1, "R11 core_run high in reset");
    push(1, 1, 0, 4'h0, "R11 fs_eff zero in reset");
    push(1, 2, 0, 4'h1, "R11 oe in reset");
    wait_cyc(2);
    rst_n = 1;
    // R8: strap capture then pins change
    wait_cyc(2);
    fs_pin = 4'b0101;
    push(3, 1, 0, 4'b1010, "R8 strap code held");
    wait_cyc(4);
    // R9: register override and back
    fs_sel = 1; fs_reg = 4'b0011;
    push(1, 1, 0, 4'b0011, "R9 register code selected");
    wait_cyc(2);
    fs_sel = 0;
    push(1, 1, 0, 4'b1010, "R9 pin code selected again");
    wait_cyc(2);
    // R10: tristate
    hiz = 1;
    push(1, 2, 0, 4'h0, "R10 pads high impedance");
    wait_cyc(2);
    hiz = 0;
    push(1, 2, 0, 4'h1, "R10 pads driven");
    wait_cyc(20);
    // R6/R7 baseline activity
    open_window();
    for (int i = 0; i <= N; i++) push(40, 3, i, 4'h1, "R6 output active when enabled");
    wait_cyc(41);
    // R6: one output disabled
    en = 4'b1011;
    wait_cyc(15);
    open_window();
    for (int i = 0; i < N; i++) push(40, 3, i, {3'b0, en[i]}, "R6 per-output enable");
    push(40, 3, N, 4'h1, "R7 free output with partial enables");
    wait_cyc(41);
    // R7: all enables cleared
    en = '0;
    wait_cyc(15);
    open_window();
    for (int i = 0; i < N; i++) push(40, 3, i, 4'h0, "R6 disabled output silent");
    push(40, 3, N, 4'h1, "R7 free output ignores enables");
    wait_cyc(41);
    en = '1;
    wait_cyc(15);
    // R2: one-edge glitch ignored
    pd_n = 0;
    wait_cyc(1);
    pd_n = 1;
    for (int d = 1; d <= 5; d++) push(d, 0, 0, 4'h1, "R2 short pulse ignored");
    wait_cyc(8);
    // R2: two-edge pulse accepted
    pd_n = 0;
    push(3, 0, 0, 4'h1, "R2 two-edge pulse before 4th edge");
    push(4, 0, 0, 4'h0, "R2 two-edge pulse accepted");
    push(5, 0, 0, 4'h1, "R2 two-edge pulse released");
    wait_cyc(2);
    pd_n = 1;
    wait_cyc(20);
    // R1/R4: full power-down
    pd_n = 0;
    push(3, 0, 0, 4'h1, "R1 still running at 3rd edge");
    push(4, 0, 0, 4'h0, "R1 core stopped at 4th edge");
    wait_cyc(20);
    open_window();
    for (int i = 0; i <= N; i++) push(40, 3, i, 4'h0, "R4 output silent in power-down");
    push(40, 4, 0, 4'h0, "R4 all outputs low in power-down");
    wait_cyc(41);
    // R3: release
    pd_n = 1;
    push(2, 0, 0, 4'h0, "R3 still stopped at 2nd edge");
    push(3, 0, 0, 4'h1, "R3 core running at 3rd edge");
    wait_cyc(20);
    open_window();
    for (int i = 0; i <= N; i++) push(40, 3, i, 4'h1, "R3 output resumed");
    wait_cyc(41);
    // R5: no truncated pulse seen anywhere
    push(1, 5, 0, 4'h0, "R5 pulse widths");
    wait_cyc(3);
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule